// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Arbiter

This block keeps an asynchronous DRAM's contents alive. A free-running timer splits the retention period into one slot per row. Each slot adds one pending refresh. The pending refreshes are served between host accesses. When the block wins the shared strobes, it runs one refresh cycle. A mode input picks the kind of cycle. In counter mode, CAS goes low ahead of RAS and the device supplies the row. In address mode, CAS stays high and the block drives the row from its own counter.

After reset, the block holds the strobes idle for a power-up pause. It then runs a burst of wake-up cycles and only after that tells the access controller that normal accesses may begin. The same wake-up burst is replayed if no refresh has started for a whole retention period. This happens when the host keeps a page open for too long.

The access controller side is a plain control handshake with no data stream. The controller reports whether it wants the bus (`host_req`) and whether its page is closed (`page_closed`). The block answers with `host_go`, which marks a cycle in which the controller may open a page. It also drives `ref_grant`, which stays high for the whole refresh cycle, precharge included. Back-pressure on the host is only the absence of `host_go`.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `dram_addr` is 0, and `ready`, `ref_grant` and `host_go` are 0.
- R2: After reset the strobes stay idle for PWRUP_CYC cycles. Exactly WAKE_CNT refresh cycles then run, each started only while `page_closed` is 1. `ready` rises in the cycle after the last one's precharge ends.
- R3: A refresh cycle begins, and `ref_grant` rises, only if `page_closed` was 1 in the cycle before. `ref_grant` stays 1 from the first strobe phase through the end of precharge.
- R4: Counter-mode cycle (`mode_cbr`=1): CAS low for T_CSR cycles with RAS high, then RAS low for T_RAS cycles with CAS kept low for the first T_CHR of them, then both high for max(T_RP,T_CPN) cycles. `dram_we_n` is always 1 and `dram_addr` is 0 in this mode.
- R5: Address-mode cycle (`mode_cbr`=0): CAS high throughout. The row is on `dram_addr` for T_ASR cycles before RAS falls and stays stable while RAS is low for T_RAS cycles. Precharge then lasts max(T_RP,T_CPN) cycles.
- R6: The internal row counter starts at 0 and advances by one at the end of each address-mode cycle, wrapping from ROWS-1 to 0. Counter-mode cycles leave it unchanged.
- R7: One refresh becomes pending every floor(REFRESH_PERIOD_CYC/ROWS) cycles, counted from reset. At most MAX_PEND refreshes may be pending. Pending refreshes are cleared whenever `ready` is 0.
- R8: While `ready` is 1, a pending refresh starts when the cycle generator is idle, `page_closed` is 1, and either `host_req` is 0 or MAX_PEND refreshes are pending. `host_go` is 1 exactly when `ready` is 1, no refresh is running and none starts that cycle.
- R9: If `ready` is 1 and no refresh starts for REFRESH_PERIOD_CYC consecutive cycles, `ready` drops and the R2 wake-up burst (without the pause) is repeated.
- R10: `mode_cbr` is sampled only when a cycle starts; changing it mid-cycle does not alter that cycle's strobes or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_cbr | input | 1 | 1: counter-mode refresh, 0: address-mode refresh |
| host_req | input | 1 | Access controller wants the bus |
| page_closed | input | 1 | Access controller has no open row |
| ready | output | 1 | Initialisation done; normal accesses allowed |
| host_go | output | 1 | Controller may open a page this cycle |
| ref_grant | output | 1 | Refresh cycle owns the strobes |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, held high |
| dram_addr | output | ROW_W | Row address for address-mode refresh |

## Verification
The assertions assume the access controller obeys the handshake. It opens a page only in cycles where `host_go` is 1, and it reports `page_closed` truthfully, so a refresh never overlaps an open row. The stimulus holds `host_req` and `page_closed` as whole-level phases that change only on the falling clock edge. It never claims a closed page while pretending to drive the strobes. The long page-open phases are timed to cross the pending cap and, separately, the retention limit. Toggling `mode_cbr` every few cycles exercises the per-cycle mode latch.

// File: rtl/ref_pkg.sv
package ref_pkg;
  typedef enum logic [1:0] {
    CY_IDLE   = 2'd0,
    CY_SETUP  = 2'd1,
    CY_STROBE = 2'd2,
    CY_PRECH  = 2'd3
  } cyc_state_t;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] tcnt;

  assign tick = (tcnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (tick) begin
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/ref_pending_arb.sv
module ref_pending_arb #(
  parameter int MAX_PEND = 8,
  parameter int PDW      = $clog2(MAX_PEND + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           tick,
  input  logic           busy,
  input  logic           page_closed,
  input  logic           host_req,
  output logic           start_run,
  output logic [PDW-1:0] pend
);
  logic [PDW:0]   sum;
  logic [PDW-1:0] pend_nxt;
  logic           urgent;

  assign urgent    = (pend == PDW'(MAX_PEND));
  assign start_run = run && !busy && (pend != '0) && page_closed
                     && (!host_req || urgent);

  always_comb begin
    sum = {1'b0, pend} + {{PDW{1'b0}}, tick};
    if (sum > (PDW+1)'(MAX_PEND)) begin
      sum = (PDW+1)'(MAX_PEND);
    end
    sum      = sum - {{PDW{1'b0}}, start_run};
    pend_nxt = sum[PDW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (!run) begin
      pend <= '0;
    end else begin
      pend <= pend_nxt;
    end
  end
endmodule

// File: rtl/ref_cycle_gen.sv
module ref_cycle_gen
  import ref_pkg::*;
#(
  parameter int ROWS  = 512,
  parameter int ROW_W = $clog2(ROWS),
  parameter int T_CSR = 2,
  parameter int T_CHR = 2,
  parameter int T_ASR = 1,
  parameter int T_RAS = 6,
  parameter int T_PRE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_cbr,
  output logic             busy,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr
);
  localparam int M1   = (T_CSR > T_ASR) ? T_CSR : T_ASR;
  localparam int M2   = (T_RAS > T_PRE) ? T_RAS : T_PRE;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXT + 1);

  cyc_state_t       st;
  logic [CW-1:0]    cnt;
  logic             mode_l;
  logic [ROW_W-1:0] row;
  logic [CW-1:0]    setup_last;

  assign setup_last = mode_l ? CW'(T_CSR - 1) : CW'(T_ASR - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= CY_IDLE;
      cnt    <= '0;
      mode_l <= 1'b0;
      row    <= '0;
    end else begin
      case (st)
        CY_IDLE: begin
          if (start) begin
            st     <= CY_SETUP;
            cnt    <= '0;
            mode_l <= mode_cbr;
          end
        end
        CY_SETUP: begin
          if (cnt == setup_last) begin
            st  <= CY_STROBE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CY_STROBE: begin
          if (cnt == CW'(T_RAS - 1)) begin
            st  <= CY_PRECH;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(T_PRE - 1)) begin
            st  <= CY_IDLE;
            cnt <= '0;
            if (!mode_l) begin
              row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy  = (st != CY_IDLE);
  assign ras_n = (st != CY_STROBE);
  assign cas_n = !(mode_l && ((st == CY_SETUP) ||
                   ((st == CY_STROBE) && (cnt < CW'(T_CHR)))));
  assign addr  = (busy && !mode_l) ? row : '0;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import ref_pkg::*;
#(
  parameter int ROWS               = 512,
  parameter int ROW_W              = $clog2(ROWS),
  parameter int REFRESH_PERIOD_CYC = 800000,
  parameter int PWRUP_CYC          = 20000,
  parameter int WAKE_CNT           = 8,
  parameter int MAX_PEND           = 8,
  parameter int T_CSR              = 2,
  parameter int T_CHR              = 2,
  parameter int T_ASR              = 1,
  parameter int T_RAS              = 6,
  parameter int T_RP               = 4,
  parameter int T_CPN              = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cbr,
  input  logic             host_req,
  input  logic             page_closed,
  output logic             ready,
  output logic             host_go,
  output logic             ref_grant,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic [ROW_W-1:0] dram_addr
);
  localparam int INTERVAL = REFRESH_PERIOD_CYC / ROWS;
  localparam int T_PRE    = (T_RP > T_CPN) ? T_RP : T_CPN;
  localparam int PDW      = $clog2(MAX_PEND + 1);
  localparam int PW       = $clog2(PWRUP_CYC + 1);
  localparam int WW       = $clog2(WAKE_CNT + 1);
  localparam int IW       = $clog2(REFRESH_PERIOD_CYC + 1);

  phase_t         phase;
  logic [PW-1:0]  pcnt;
  logic [WW-1:0]  wake_left;
  logic [IW-1:0]  idle_cnt;
  logic           tick;
  logic           busy;
  logic           start_run;
  logic           start_wake;
  logic           start;
  logic [PDW-1:0] pend_cnt;

  ref_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  ref_pending_arb #(.MAX_PEND(MAX_PEND), .PDW(PDW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (phase == PH_RUN),
    .tick       (tick),
    .busy       (busy),
    .page_closed(page_closed),
    .host_req   (host_req),
    .start_run  (start_run),
    .pend       (pend_cnt)
  );

  assign start_wake = (phase == PH_WAKE) && !busy && page_closed
                      && (wake_left != '0);
  assign start      = start_run || start_wake;

  ref_cycle_gen #(
    .ROWS (ROWS),
    .ROW_W(ROW_W),
    .T_CSR(T_CSR),
    .T_CHR(T_CHR),
    .T_ASR(T_ASR),
    .T_RAS(T_RAS),
    .T_PRE(T_PRE)
  ) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode_cbr(mode_cbr),
    .busy    (busy),
    .ras_n   (dram_ras_n),
    .cas_n   (dram_cas_n),
    .addr    (dram_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_PAUSE;
      pcnt      <= '0;
      wake_left <= '0;
      idle_cnt  <= '0;
    end else begin
      case (phase)
        PH_PAUSE: begin
          if (pcnt == PW'(PWRUP_CYC - 1)) begin
            phase     <= PH_WAKE;
            wake_left <= WW'(WAKE_CNT);
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        PH_WAKE: begin
          if (start_wake) begin
            wake_left <= wake_left - 1'b1;
          end
          if ((wake_left == '0) && !busy) begin
            phase    <= PH_RUN;
            idle_cnt <= '0;
          end
        end
        default: begin
          if (start_run) begin
            idle_cnt <= '0;
          end else if (idle_cnt == IW'(REFRESH_PERIOD_CYC - 1)) begin
            phase     <= PH_WAKE;
            wake_left <= WW'(WAKE_CNT);
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign ready     = (phase == PH_RUN);
  assign ref_grant = busy;
  assign host_go   = ready && !busy && !start;
  assign dram_we_n = 1'b1;
endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
  parameter int ROW_W    = 9,
  parameter int PDW      = 4,
  parameter int MAX_PEND = 8,
  parameter int WAKE_CNT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             page_closed,
  input logic             ready,
  input logic             ref_grant,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] addr,
  input logic [PDW-1:0]   pend
);
  logic [7:0] wk_seen;
  logic       ras_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_seen <= '0;
      ras_q   <= 1'b1;
    end else begin
      ras_q <= ras_n;
      if (ready) begin
        wk_seen <= '0;
      end else if (ras_q && !ras_n && (wk_seen != 8'hFF)) begin
        wk_seen <= wk_seen + 1'b1;
      end
    end
  end

  a_r1_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_grant |-> (ras_n && cas_n && (addr == '0)));

  a_r2_wake_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (wk_seen >= 8'(WAKE_CNT)));

  a_r3_grant_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_grant) |-> $past(page_closed));

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  a_r5_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n) |-> ($past(cas_n) && ($past(addr) == addr)));

  a_r5_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n)) |-> $stable(addr));

  a_r7_pend_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PDW'(MAX_PEND));

  a_r8_urgent_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ref_grant && page_closed && (pend == PDW'(MAX_PEND)))
    |=> ref_grant);
endmodule

bind dram_refresh_sched ref_sched_chk #(
  .ROW_W   (ROW_W),
  .PDW     (PDW),
  .MAX_PEND(MAX_PEND),
  .WAKE_CNT(WAKE_CNT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .page_closed(page_closed),
  .ready      (ready),
  .ref_grant  (ref_grant),
  .ras_n      (dram_ras_n),
  .cas_n      (dram_cas_n),
  .addr       (dram_addr),
  .pend       (pend_cnt)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int ROWS   = 16;
  localparam int ROW_W  = 4;
  localparam int PERIOD = 1600;
  localparam int PWR    = 50;
  localparam int WAKE   = 8;
  localparam int MAXP   = 3;
  localparam int TCSR   = 2;
  localparam int TCHR   = 2;
  localparam int TASR   = 1;
  localparam int TRAS   = 4;
  localparam int TRP    = 3;
  localparam int TCPN   = 2;
  localparam int INTV   = PERIOD / ROWS;
  localparam int TPRE   = (TRP > TCPN) ? TRP : TCPN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_cbr = 1'b1;
  logic host_req = 1'b0;
  logic page_closed = 1'b1;
  logic ready, host_go, ref_grant, dram_ras_n, dram_cas_n, dram_we_n;
  logic [ROW_W-1:0] dram_addr;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .ROWS(ROWS), .ROW_W(ROW_W), .REFRESH_PERIOD_CYC(PERIOD),
    .PWRUP_CYC(PWR), .WAKE_CNT(WAKE), .MAX_PEND(MAXP),
    .T_CSR(TCSR), .T_CHR(TCHR), .T_ASR(TASR), .T_RAS(TRAS),
    .T_RP(TRP), .T_CPN(TCPN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode_cbr(mode_cbr), .host_req(host_req),
    .page_closed(page_closed), .ready(ready), .host_go(host_go),
    .ref_grant(ref_grant), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: phase 0 pause, 1 wake, 2 run; cycle 0 idle, 1 setup, 2 low, 3 precharge
  int m_phase, m_pc, m_wake, m_idle, m_tc, m_pend, m_st, m_cnt, m_mode, m_row;

  function automatic bit m_start_run();
    return (m_phase == 2) && (m_st == 0) && (m_pend > 0) && page_closed
           && (!host_req || (m_pend == MAXP));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_pc = 0; m_wake = 0; m_idle = 0; m_tc = 0;
      m_pend = 0; m_st = 0; m_cnt = 0; m_mode = 0; m_row = 0;
    end else begin
      bit busy, tk, sr, sw;
      int np, old_wake;
      busy = (m_st != 0);
      tk   = (m_tc == INTV - 1);
      sr   = m_start_run();
      sw   = (m_phase == 1) && !busy && page_closed && (m_wake > 0);
      m_tc = tk ? 0 : m_tc + 1;
      if (m_phase != 2) np = 0;
      else begin
        np = m_pend + (tk ? 1 : 0);
        if (np > MAXP) np = MAXP;
        if (sr) np = np - 1;
      end
      m_pend = np;
      old_wake = m_wake;
      case (m_phase)
        0: if (m_pc == PWR - 1) begin m_phase = 1; m_wake = WAKE; end
           else m_pc = m_pc + 1;
        1: begin
             if (sw) m_wake = m_wake - 1;
             if (old_wake == 0 && !busy) begin m_phase = 2; m_idle = 0; end
           end
        default: if (sr) m_idle = 0;
                 else if (m_idle == PERIOD - 1) begin m_phase = 1; m_wake = WAKE; end
                 else m_idle = m_idle + 1;
      endcase
      case (m_st)
        0: if (sr || sw) begin m_st = 1; m_cnt = 0; m_mode = mode_cbr; end
        1: if (m_cnt == (m_mode ? TCSR : TASR) - 1) begin m_st = 2; m_cnt = 0; end
           else m_cnt++;
        2: if (m_cnt == TRAS - 1) begin m_st = 3; m_cnt = 0; end
           else m_cnt++;
        default: if (m_cnt == TPRE - 1) begin
                   m_st = 0; m_cnt = 0;
                   if (!m_mode) m_row = (m_row + 1) % ROWS;
                 end else m_cnt++;
      endcase
    end
  end

  // Observation state for scenario checks
  bit prev_ras = 1, prev_ready = 0, prev_grant = 0;
  int wake_falls = 0, first_fall = -1, last_row = -1, wraps = 0;
  int grant_rises = 0, ready_drops = 0;

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      bit e_ras, e_cas, e_go;
      int e_addr;
      e_ras  = !(m_st == 2);
      e_cas  = !(m_mode && (m_st == 1 || (m_st == 2 && m_cnt < TCHR)));
      e_addr = (m_st != 0 && !m_mode) ? m_row : 0;
      e_go   = (m_phase == 2) && (m_st == 0) && !m_start_run();
      chk(dram_ras_n == e_ras, "R4/R5 ras_n", dram_ras_n, e_ras);
      chk(dram_cas_n == e_cas, "R4/R10 cas_n", dram_cas_n, e_cas);
      chk(dram_we_n == 1'b1, "R4 we_n", dram_we_n, 1);
      chk(int'(dram_addr) == e_addr, "R5/R6 addr", dram_addr, e_addr);
      chk(ref_grant == (m_st != 0), "R3/R7 ref_grant", ref_grant, m_st != 0);
      chk(ready == (m_phase == 2), "R2/R9 ready", ready, m_phase == 2);
      chk(host_go == e_go, "R8 host_go", host_go, e_go);

      if (prev_ras && !dram_ras_n) begin
        if (first_fall < 0) first_fall = cyc;
        if (!ready) wake_falls++;
        if (dram_cas_n) begin
          if (last_row >= 0) begin
            chk(int'(dram_addr) == (last_row + 1) % ROWS, "R6 row step",
                dram_addr, (last_row + 1) % ROWS);
            if (last_row == ROWS - 1) wraps++;
          end
          last_row = dram_addr;
        end
      end
      if (!prev_ready && ready) begin
        chk(wake_falls == WAKE, "R2 wake cycle count", wake_falls, WAKE);
        wake_falls = 0;
      end
      if (prev_ready && !ready) ready_drops++;
      if (!prev_grant && ref_grant) grant_rises++;
      prev_ras = dram_ras_n; prev_ready = ready; prev_grant = ref_grant;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int g0;
    run_cycles(3);
    // R1: reset values
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset", {dram_ras_n, dram_cas_n}, 3);
    chk(!ready && !ref_grant && !host_go && dram_addr == 0, "R1 control in reset",
        {ready, ref_grant, host_go}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ready && !ref_grant && dram_ras_n, "R1 first cycle after reset", ready, 0);

    // R2: power-up pause and wake-up burst in counter mode
    wait (ready);
    run_cycles(1);
    chk(first_fall >= PWR, "R2 pause before first strobe", first_fall, PWR);

    // R7: refresh rate with idle host
    g0 = grant_rises;
    run_cycles(1000);
    chk((grant_rises - g0) >= 9 && (grant_rises - g0) <= 11, "R7 refresh rate",
        grant_rises - g0, 1000 / INTV);

    // R5/R6: address mode, long enough to wrap the row counter
    mode_cbr = 1'b0;
    run_cycles(2000);
    chk(wraps > 0, "R6 row wrap seen", wraps, 1);

    // R8: host holds an open page, pending reaches the cap, then page closes with host still requesting
    host_req = 1'b1; page_closed = 1'b0;
    run_cycles(450);
    chk(ready == 1'b1, "R8 still ready while held", ready, 1);
    page_closed = 1'b1;
    run_cycles(600);

    // R9: page held open past the retention limit forces a new wake-up
    page_closed = 1'b0;
    run_cycles(1800);
    chk(ready_drops >= 1, "R9 ready dropped after idle limit", ready_drops, 1);
    chk(!ready, "R9 wake blocked by open page", ready, 0);
    page_closed = 1'b1; host_req = 1'b0;
    run_cycles(300);
    chk(ready == 1'b1, "R9 ready restored after wake-up", ready, 1);

    // R10: mode toggled mid-cycle
    for (int i = 0; i < 200; i++) begin
      mode_cbr = ~mode_cbr;
      run_cycles(3);
    end
    host_req = 1'b1;
    for (int i = 0; i < 100; i++) begin
      mode_cbr = ~mode_cbr;
      run_cycles(5);
    end
    run_cycles(20);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule